// File: doc/BRIEF.md
# Secure Configuration Load Gate

This block sits in front of a device's configuration loader. It decides whether an incoming configuration stream may load. The decision depends on three things: which keys have been programmed, whether the stream header says the stream is encrypted, and which configuration port carries it. The block holds the key state. That state is a rewritable volatile key, a write-once non-volatile key and a one-way tamper lock. Key programming arrives as simple register writes. Stored key values never leave the block; only a presence flag and the lock state are visible.

For each load request, the gate reports its verdict as a one-cycle accept or reject pulse. For an accepted stream it then raises the decrypt, decompress and fast-clock indications for the duration of the load, and a test-load flag when an unencrypted stream is loaded into a keyed device. The decryption engine itself is not modelled. Each incoming data word produces a decrypt-stage strobe followed one cycle later by a decompress-stage strobe, so that downstream logic sees decryption strictly before decompression. A rejected stream holds the done output low until the next request.

Top module: `secure_cfg_gate`

## Requirements
- R1: With no key programmed, an unencrypted stream is accepted on every port and an encrypted stream is rejected.
- R2: With a volatile or non-volatile key and the lock clear, an unencrypted stream is accepted with `test_load`=1. An encrypted stream on a non-JTAG port is accepted with `test_load`=0.
- R3: An encrypted stream on the JTAG port (`port_sel`=3) is rejected in every key state.
- R4: Once the tamper lock is set, only encrypted streams on ports 0 to 2 are accepted; every unencrypted stream is rejected, JTAG included.
- R5: While an accepted load runs, `dec_en` equals the encryption flag and `dcmp_en` equals the compression flag. `clk_x4` is 1 only for a decrypted stream on the parallel port (`port_sel`=0).
- R6: A `data_valid` cycle during a load produces `dec_stb` on the next cycle when decrypting, and `dcmp_stb` one cycle after that. Without decryption, `dcmp_stb` follows `data_valid` by one cycle and `dec_stb` stays low.
- R7: Operation 0 writes the volatile key and operation 1 erases it. A key value of zero counts as absent, and `key_present` is 1 whenever either key is non-zero.
- R8: Operation 2 programs the non-volatile key once. A further write, or a write of zero, is ignored and sets the sticky `violation` flag.
- R9: Operation 3 sets the tamper lock only if the non-volatile key is programmed; otherwise it is ignored and sets `violation`. Operation 4 (clear) never changes the lock and always sets `violation`.
- R10: A rejected request gives a one-cycle `load_bad` pulse. After it, `cfg_done`, the enables and the strobes stay low until the next request.
- R11: An accepted request gives a one-cycle `load_ok` pulse. `load_end` during the load raises `cfg_done`, which holds until the next request.
- R12: After reset all outputs are 0 and no key or lock is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kw_valid | input | 1 | Key-programming operation valid |
| kw_op | input | 3 | Operation: 0 vol write, 1 vol erase, 2 nv write, 3 lock set, 4 lock clear |
| kw_data | input | KEY_W | Key value for write operations |
| load_req | input | 1 | Start of a configuration load; header fields sampled |
| hdr_enc | input | 1 | Stream header: encrypted |
| hdr_cmp | input | 1 | Stream header: compressed |
| port_sel | input | 2 | 0 parallel, 1 active serial, 2 passive serial, 3 JTAG |
| data_valid | input | 1 | Configuration data word present |
| load_end | input | 1 | Last word of the stream delivered |
| load_ok | output | 1 | Accept pulse |
| load_bad | output | 1 | Reject pulse |
| test_load | output | 1 | Accepted stream is an unencrypted load into a keyed device |
| dec_en | output | 1 | Decryption active for the running load |
| dcmp_en | output | 1 | Decompression active for the running load |
| clk_x4 | output | 1 | Source clock must run at four times the data rate |
| dec_stb | output | 1 | Decrypt-stage strobe per word |
| dcmp_stb | output | 1 | Decompress-stage strobe per word |
| cfg_done | output | 1 | Accepted load completed |
| key_present | output | 1 | Some key is programmed |
| tamper_locked | output | 1 | Tamper lock set |
| violation | output | 1 | Sticky illegal key-operation flag |

## Verification
The bench walks the key state from empty, through volatile and non-volatile keys, to locked. In each state it requests loads on every port with both header flags, so a gate that let an encrypted stream through JTAG, or an unencrypted stream through a locked device, shows a wrong verdict pulse. It attempts a second non-volatile write, a lock without a key and a lock clear. A design that obeyed any of these would show a changed lock state, a missing violation flag, or a different verdict for the next load. Words streamed through a decrypted, compressed load check that the decompress strobe trails the decrypt strobe by one cycle. Words sent after a rejection check that no strobe and no done indication appear.

// File: rtl/sec_cfg_pkg.sv
// Package: shared encodings for the secure configuration load gate.
// Assumes the port and key-operation codes are fixed by the surrounding loader.
package sec_cfg_pkg;

    typedef enum logic [1:0] {
        PORT_PAR  = 2'd0,
        PORT_ASER = 2'd1,
        PORT_PSER = 2'd2,
        PORT_JTAG = 2'd3
    } cfg_port_e;

    typedef enum logic [1:0] {
        MODE_NOKEY  = 2'd0,
        MODE_VOL    = 2'd1,
        MODE_NV     = 2'd2,
        MODE_LOCKED = 2'd3
    } key_mode_e;

    typedef enum logic [2:0] {
        KOP_VOL_SET  = 3'd0,
        KOP_VOL_CLR  = 3'd1,
        KOP_NV_SET   = 3'd2,
        KOP_LOCK_SET = 3'd3,
        KOP_LOCK_CLR = 3'd4
    } key_op_e;

    typedef struct packed {
        logic accept;
        logic test;
        logic dec;
        logic dcmp;
        logic x4;
    } verdict_t;

endpackage

// File: rtl/key_vault.sv
// Key vault: holds the volatile key, the write-once non-volatile key and the
// one-way tamper lock. Illegal operations are dropped and set a sticky flag.
// Assumes a zero key value means "no key"; key bits never leave this module.
module key_vault
    import sec_cfg_pkg::*;
#(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [2:0]       wr_op,
    input  logic [KEY_W-1:0] wr_data,
    output key_mode_e        mode_o,
    output logic             present_o,
    output logic             locked_o,
    output logic             viol_o
);

    logic [KEY_W-1:0] vol_q;
    logic [KEY_W-1:0] nv_q;
    logic             lock_q;
    logic             viol_q;
    logic             vol_set;
    logic             nv_set;
    logic             wr_zero;

    assign vol_set = |vol_q;
    assign nv_set  = |nv_q;
    assign wr_zero = ~|wr_data;

    // Apply key operations, dropping illegal ones and flagging them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q  <= '0;
            nv_q   <= '0;
            lock_q <= 1'b0;
            viol_q <= 1'b0;
        end else if (wr_valid) begin
            case (key_op_e'(wr_op))
                KOP_VOL_SET: vol_q <= wr_data;
                KOP_VOL_CLR: vol_q <= '0;
                KOP_NV_SET: begin
                    if (nv_set || wr_zero) viol_q <= 1'b1;
                    else                   nv_q   <= wr_data;
                end
                KOP_LOCK_SET: begin
                    if (!nv_set) viol_q <= 1'b1;
                    else         lock_q <= 1'b1;
                end
                KOP_LOCK_CLR: viol_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Resolve the effective key mode with the lock taking precedence.
    always_comb begin
        if (lock_q)       mode_o = MODE_LOCKED;
        else if (nv_set)  mode_o = MODE_NV;
        else if (vol_set) mode_o = MODE_VOL;
        else              mode_o = MODE_NOKEY;
    end

    assign present_o = vol_set | nv_set;
    assign locked_o  = lock_q;
    assign viol_o    = viol_q;

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_nv_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_set |=> $stable(nv_q));

    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

    assert_lock_needs_nv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(nv_set));

endmodule

// File: rtl/load_policy.sv
// Load policy: purely combinational verdict for one load request from the key
// mode, the header flags and the port. Assumes inputs are stable when sampled.
module load_policy
    import sec_cfg_pkg::*;
(
    input  key_mode_e mode_i,
    input  logic      enc_i,
    input  logic      cmp_i,
    input  logic [1:0] port_i,
    output verdict_t  verdict_o
);

    logic is_jtag;
    logic acc;

    assign is_jtag = (cfg_port_e'(port_i) == PORT_JTAG);

    // Decide acceptance per key mode.
    always_comb begin
        case (mode_i)
            MODE_NOKEY:  acc = !enc_i;
            MODE_LOCKED: acc = enc_i && !is_jtag;
            default:     acc = !(enc_i && is_jtag);
        endcase
    end

    // Derive the per-load indications from the verdict.
    always_comb begin
        verdict_o.accept = acc;
        verdict_o.test   = acc && !enc_i && (mode_i == MODE_VOL || mode_i == MODE_NV);
        verdict_o.dec    = acc && enc_i;
        verdict_o.dcmp   = acc && cmp_i;
        verdict_o.x4     = acc && enc_i && (cfg_port_e'(port_i) == PORT_PAR);
    end

    // Guard the two port-level bans next to the verdict.
    always_comb begin
        if (verdict_o.accept && enc_i)
            assert_no_jtag_enc_R3: assert (!is_jtag);
        if (verdict_o.accept && mode_i == MODE_LOCKED)
            assert_locked_enc_only_R4: assert (enc_i);
    end

endmodule

// File: rtl/load_sequencer.sv
// Load sequencer: registers the verdict, tracks the load through to done or
// rejected and produces the decrypt-then-decompress strobes per data word.
// Assumes load_req may restart a load at any time.
module load_sequencer
    import sec_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_req,
    input  logic     load_end,
    input  logic     data_valid,
    input  verdict_t verdict_i,
    output logic     ok_o,
    output logic     bad_o,
    output logic     test_o,
    output logic     dec_en_o,
    output logic     dcmp_en_o,
    output logic     x4_o,
    output logic     dec_stb_o,
    output logic     dcmp_stb_o,
    output logic     done_o
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_DONE, SQ_REJ} sq_state_e;

    sq_state_e state_q;
    logic      ok_q, bad_q, test_q, dpath_q, cmp_q, x4_q;
    logic      dstb_q, cstb_q;
    logic      in_load;

    assign in_load = (state_q == SQ_LOAD);

    // Track the load state and latch the verdict at each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ok_q    <= 1'b0;
            bad_q   <= 1'b0;
            test_q  <= 1'b0;
            dpath_q <= 1'b0;
            cmp_q   <= 1'b0;
            x4_q    <= 1'b0;
        end else begin
            ok_q  <= 1'b0;
            bad_q <= 1'b0;
            if (load_req) begin
                state_q <= verdict_i.accept ? SQ_LOAD : SQ_REJ;
                ok_q    <= verdict_i.accept;
                bad_q   <= !verdict_i.accept;
                test_q  <= verdict_i.test;
                dpath_q <= verdict_i.dec;
                cmp_q   <= verdict_i.dcmp;
                x4_q    <= verdict_i.x4;
            end else if (in_load && load_end) begin
                state_q <= SQ_DONE;
            end
        end
    end

    // Pipe each word through the decrypt stage before the decompress stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dstb_q <= 1'b0;
            cstb_q <= 1'b0;
        end else begin
            dstb_q <= in_load && data_valid && dpath_q;
            cstb_q <= dstb_q || (in_load && data_valid && !dpath_q);
        end
    end

    assign ok_o       = ok_q;
    assign bad_o      = bad_q;
    assign test_o     = test_q;
    assign dec_en_o   = in_load && dpath_q;
    assign dcmp_en_o  = in_load && cmp_q;
    assign x4_o       = in_load && x4_q;
    assign dec_stb_o  = dstb_q;
    assign dcmp_stb_o = cstb_q;
    assign done_o     = (state_q == SQ_DONE);

    assert_dec_before_dcmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dstb_q |=> cstb_q);

    assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> (!done_o && !dec_en_o && !dcmp_en_o && !x4_o));

    assert_verdict_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_q, bad_q}));

    assert_done_needs_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(load_end && in_load));

endmodule

// File: rtl/secure_cfg_gate.sv
// Secure configuration load gate: top level joining the key vault, the load
// policy and the load sequencer. Assumes one clock domain and a single loader.
module secure_cfg_gate
    import sec_cfg_pkg::*;
#(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kw_valid,
    input  logic [2:0]       kw_op,
    input  logic [KEY_W-1:0] kw_data,
    input  logic             load_req,
    input  logic             hdr_enc,
    input  logic             hdr_cmp,
    input  logic [1:0]       port_sel,
    input  logic             data_valid,
    input  logic             load_end,
    output logic             load_ok,
    output logic             load_bad,
    output logic             test_load,
    output logic             dec_en,
    output logic             dcmp_en,
    output logic             clk_x4,
    output logic             dec_stb,
    output logic             dcmp_stb,
    output logic             cfg_done,
    output logic             key_present,
    output logic             tamper_locked,
    output logic             violation
);

    key_mode_e mode;
    verdict_t  verdict;

    key_vault #(.KEY_W(KEY_W)) u_vault (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (kw_valid),
        .wr_op     (kw_op),
        .wr_data   (kw_data),
        .mode_o    (mode),
        .present_o (key_present),
        .locked_o  (tamper_locked),
        .viol_o    (violation)
    );

    load_policy u_policy (
        .mode_i    (mode),
        .enc_i     (hdr_enc),
        .cmp_i     (hdr_cmp),
        .port_i    (port_sel),
        .verdict_o (verdict)
    );

    load_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .load_end   (load_end),
        .data_valid (data_valid),
        .verdict_i  (verdict),
        .ok_o       (load_ok),
        .bad_o      (load_bad),
        .test_o     (test_load),
        .dec_en_o   (dec_en),
        .dcmp_en_o  (dcmp_en),
        .x4_o       (clk_x4),
        .dec_stb_o  (dec_stb),
        .dcmp_stb_o (dcmp_stb),
        .done_o     (cfg_done)
    );

endmodule

// File: tb/sim_secure_cfg_gate.sv
module sim_secure_cfg_gate;

    localparam int KEY_W = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kw_valid = 1'b0;
    logic [2:0] kw_op = '0;
    logic [KEY_W-1:0] kw_data = '0;
    logic load_req = 1'b0, hdr_enc = 1'b0, hdr_cmp = 1'b0;
    logic [1:0] port_sel = '0;
    logic data_valid = 1'b0, load_end = 1'b0;
    logic load_ok, load_bad, test_load, dec_en, dcmp_en, clk_x4;
    logic dec_stb, dcmp_stb, cfg_done, key_present, tamper_locked, violation;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    secure_cfg_gate #(.KEY_W(KEY_W)) u0 (.*);

    // Behavioural reference: key values, lock, verdict, load phase, strobes.
    logic [KEY_W-1:0] m_vol, m_nv;
    bit m_lock, m_viol, m_ok, m_bad, m_test, m_dec, m_cmp, m_x4, m_dstb, m_cstb;
    int m_phase; // 0 idle, 1 loading, 2 done, 3 rejected

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vol = '0; m_nv = '0; m_lock = 0; m_viol = 0; m_ok = 0; m_bad = 0;
            m_test = 0; m_dec = 0; m_cmp = 0; m_x4 = 0; m_dstb = 0; m_cstb = 0;
            m_phase = 0;
        end else begin
            bit nd, nc, acc, keyed;
            nd = (m_phase == 1) && data_valid && m_dec;
            nc = m_dstb || ((m_phase == 1) && data_valid && !m_dec);
            m_ok = 0; m_bad = 0;
            if (load_req) begin
                keyed = (m_nv != 0) || (m_vol != 0);
                if (m_lock)      acc = hdr_enc && port_sel != 2'd3;
                else if (keyed)  acc = !(hdr_enc && port_sel == 2'd3);
                else             acc = !hdr_enc;
                m_ok = acc; m_bad = !acc;
                m_phase = acc ? 1 : 3;
                m_test = acc && !hdr_enc && keyed && !m_lock;
                m_dec = acc && hdr_enc;
                m_cmp = acc && hdr_cmp;
                m_x4 = acc && hdr_enc && port_sel == 2'd0;
            end else if (m_phase == 1 && load_end) begin
                m_phase = 2;
            end
            if (kw_valid) begin
                case (kw_op)
                    3'd0: m_vol = kw_data;
                    3'd1: m_vol = '0;
                    3'd2: if (m_nv != 0 || kw_data == 0) m_viol = 1; else m_nv = kw_data;
                    3'd3: if (m_nv == 0) m_viol = 1; else m_lock = 1;
                    3'd4: m_viol = 1;
                    default: ;
                endcase
            end
            m_dstb = nd; m_cstb = nc;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the reference on each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R11 load_ok", load_ok, m_ok);
            chk("R10 load_bad", load_bad, m_bad);
            chk("R2 test_load", test_load, m_test);
            chk("R5 dec_en", dec_en, (m_phase == 1) && m_dec);
            chk("R5 dcmp_en", dcmp_en, (m_phase == 1) && m_cmp);
            chk("R5 clk_x4", clk_x4, (m_phase == 1) && m_x4);
            chk("R6 dec_stb", dec_stb, m_dstb);
            chk("R6 dcmp_stb", dcmp_stb, m_cstb);
            chk("R11 cfg_done", cfg_done, m_phase == 2);
            chk("R7 key_present", key_present, (m_vol != 0) || (m_nv != 0));
            chk("R9 tamper_locked", tamper_locked, m_lock);
            chk("R8 violation", violation, m_viol);
        end
    end

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic key_op(input logic [2:0] op, input logic [KEY_W-1:0] val);
        @(posedge clk); #1 kw_valid = 1'b1; kw_op = op; kw_data = val;
        @(posedge clk); #1 kw_valid = 1'b0; kw_data = '0;
    endtask

    // Issue a request and check its verdict pulse directly.
    task automatic try_load(input bit enc, input bit cmp, input logic [1:0] port,
                            input bit exp_ok, input string tag);
        @(posedge clk); #1 load_req = 1'b1; hdr_enc = enc; hdr_cmp = cmp; port_sel = port;
        @(posedge clk); #1 load_req = 1'b0;
        @(negedge clk);
        chk(tag, {load_ok, load_bad}, {exp_ok, !exp_ok});
    endtask

    task automatic stream(input int words);
        for (int i = 0; i < words; i++) begin
            @(posedge clk); #1 data_valid = 1'b1;
        end
        @(posedge clk); #1 data_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 load_end = 1'b1;
        @(posedge clk); #1 load_end = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        do_reset();
        cmp_on = 1'b1;
        @(negedge clk);
        // R12: outputs idle after reset
        chk("R12 reset outputs", {load_ok, load_bad, test_load, dec_en, dcmp_en, clk_x4,
            dec_stb, dcmp_stb, cfg_done, key_present, tamper_locked, violation}, 32'd0);

        // R1: no key
        for (int p = 0; p < 4; p++) begin
            try_load(1'b0, 1'b1, p[1:0], 1'b1, "R1 nokey plain");
            stream(2);
        end
        try_load(1'b1, 1'b0, 2'd0, 1'b0, "R1 nokey enc");
        stream(2); // R10: words after reject produce nothing
        @(negedge clk); chk("R10 no done after reject", cfg_done, 1'b0);

        // R7 / R5 / R6 / R3 / R2 with a volatile key
        key_op(3'd0, {KEY_W/32{32'hA5C3_0F1E}});
        try_load(1'b1, 1'b1, 2'd0, 1'b1, "R5 vol enc par");
        @(negedge clk); chk("R5 x4 on parallel", clk_x4, 1'b1);
        stream(4);
        try_load(1'b1, 1'b0, 2'd3, 1'b0, "R3 vol enc jtag");
        try_load(1'b0, 1'b0, 2'd3, 1'b1, "R2 vol plain jtag");
        @(negedge clk); chk("R2 test flag", test_load, 1'b1);
        stream(1);
        try_load(1'b1, 1'b1, 2'd1, 1'b1, "R5 vol enc aser");
        @(negedge clk); chk("R5 no x4 on serial", clk_x4, 1'b0);
        stream(3);
        key_op(3'd1, '0);
        try_load(1'b1, 1'b0, 2'd2, 1'b0, "R7 erased key rejects enc");

        // R8 non-volatile key write-once
        key_op(3'd2, {KEY_W/32{32'h1357_9BDF}});
        @(negedge clk); chk("R8 nv ok no violation", violation, 1'b0);
        key_op(3'd2, {KEY_W/32{32'h2468_ACE0}});
        @(negedge clk); chk("R8 nv rewrite flagged", violation, 1'b1);
        try_load(1'b0, 1'b0, 2'd2, 1'b1, "R2 nv plain pser");
        stream(1);

        // R4 locked
        key_op(3'd3, '0);
        @(negedge clk); chk("R9 lock set", tamper_locked, 1'b1);
        try_load(1'b0, 1'b0, 2'd0, 1'b0, "R4 locked plain par");
        try_load(1'b0, 1'b0, 2'd3, 1'b0, "R4 locked plain jtag");
        try_load(1'b1, 1'b0, 2'd3, 1'b0, "R3 locked enc jtag");
        try_load(1'b1, 1'b1, 2'd2, 1'b1, "R4 locked enc pser");
        stream(3);
        key_op(3'd4, '0);
        @(negedge clk); chk("R9 lock not clearable", tamper_locked, 1'b1);
        key_op(3'd0, {KEY_W/32{32'h0000_0001}});
        try_load(1'b0, 1'b1, 2'd1, 1'b0, "R4 locked ignores vol key");

        // R9 lock without non-volatile key
        do_reset();
        key_op(3'd3, '0);
        @(negedge clk); chk("R9 lock needs nv", {tamper_locked, violation}, 2'b01);
        try_load(1'b0, 1'b0, 2'd0, 1'b1, "R1 nokey after bad lock");
        stream(1);

        // R8 zero nv write
        do_reset();
        key_op(3'd2, '0);
        @(negedge clk); chk("R8 zero nv write", {key_present, violation}, 2'b01);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule